// File: doc/BRIEF.md
# Bus Clock Stop Controller

This block derives a bus clock from a faster reference clock and drives two copies of it. One is a free-running bus clock. The other is a 7-bit group of gated bus clocks that can be parked for power saving. Software or a power manager requests the stop with an active-low input that may change at any time. The block synchronizes that input in the reference domain. It then turns the gated group off and on only at clean bus-clock boundaries. Outputs park low, and every high phase has full width.

A state machine sequences each stop and restart. It has five states:

- `ST_RUN_MIN` is the guaranteed-on window after reset or after a restart.
- `ST_RUN` means a stop may be accepted.
- `ST_DRAIN` lets one more full bus cycle through.
- `ST_OFF` holds the gated bus parked low.
- `ST_WAKE` counts bus rising edges before the group is re-enabled.

The transitions are:

- *window done* (`ST_RUN_MIN` to `ST_RUN`) on the tenth gated rising edge.
- *stop seen* (`ST_RUN` to `ST_DRAIN`) when the synchronized request is active and the qualifier is high.
- *park* (`ST_DRAIN` to `ST_OFF`) on the bus falling edge that follows one more rising edge.
- *release seen* (`ST_OFF` to `ST_WAKE`) when the effective request drops.
- *resume* (`ST_WAKE` to `ST_RUN_MIN`) on the bus falling edge after the second counted rising edge.

A stop-permit qualifier gates the request. While the qualifier is low, a stop request has no effect.

Top module: `busclk_stop_ctrl`

## Requirements
- R1: While reset is asserted, both clock outputs are low. After reset the gated bus runs in phase with the free-running clock, and the minimum-on window starts from zero. With the stop request held active through and after reset, exactly 11 gated rising edges appear before the group parks.
- R2: `free_clk` toggles every `HALF_DIV` (default 2) reference cycles in every state and is never affected by the stop request.
- R3: The stop request passes through a two-flop synchronizer. The request may be driven low on the reference falling edge that follows a `free_clk` rising edge while in `ST_RUN`. In that case exactly one further gated rising edge appears, and then the group parks.
- R4: While stopped, every bit of `gclk` stays low and shows no rising edge.
- R5: The request may be released on the reference falling edge that follows a `free_clk` rising edge. In that case the first gated rising edge coincides with the third `free_clk` rising edge after the release.
- R6: Every gated high phase lasts exactly `HALF_DIV` reference cycles, and every gated low phase lasts at least `HALF_DIV`. There are no runt pulses.
- R7: After each enable, at least 10 gated rising edges occur before the group can be disabled. A request asserted right after the first restarted pulse yields exactly 11 gated rising edges.
- R8: While `stop_qual` is low, a stop request is ignored and `gclk` keeps pace with `free_clk`. When `stop_qual` goes high with the request active, the group stops. When `stop_qual` goes low again, the group restarts.
- R9: All bits of `gclk` are identical at all times.
- R10: The internal gate enable changes only while the bus clock is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock; all state is in this domain |
| rst_n | input | 1 | Active-low reset, synchronous to `clk_ref` |
| stop_n_async | input | 1 | Active-low asynchronous stop request |
| stop_qual | input | 1 | Stop permit; a request acts only while this is high |
| free_clk | output | 1 | Free-running bus clock |
| gclk | output | GCLK_W (7) | Gated bus clock group |

## Verification
The gated group is tried under four patterns:

- A request held across reset shows whether the minimum-on counter really starts cleared.
- A request asserted at a fixed bus phase while fully running separates a correct one-cycle drain from an early or late park.
- A release at a fixed phase distinguishes a three-edge wake from a two- or four-edge one.
- A request asserted right after a restart tells a honoured minimum-on window from an immediate stop.

Toggling the qualifier separates a qualified request from an unconditional one. Continuous pulse-width monitors on both outputs catch runt or shortened phases in any of these patterns.

// File: rtl/busclk_stop_pkg.sv
package busclk_stop_pkg;
    typedef enum logic [2:0] {
        ST_RUN_MIN,
        ST_RUN,
        ST_DRAIN,
        ST_OFF,
        ST_WAKE
    } gate_state_e;
endpackage

// File: rtl/busclk_sync.sv
// Multi-flop synchronizer for a single asynchronous level.
module busclk_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/busclk_div.sv
// Bus clock phase generator: divides the reference by 2*HALF_DIV.
module busclk_div #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic bus_q,
    output logic nxt_hi,
    output logic rise_t,
    output logic fall_t
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] ph_q;
    logic          tick;

    assign tick   = (ph_q == CW'(HALF_DIV - 1));
    assign rise_t = tick & ~bus_q;
    assign fall_t = tick &  bus_q;
    assign nxt_hi = tick ? ~bus_q : bus_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= '0;
            bus_q <= 1'b0;
        end else begin
            ph_q  <= tick ? '0 : ph_q + CW'(1);
            bus_q <= nxt_hi;
        end
    end
endmodule

// File: rtl/busclk_gate_fsm.sv
// Sequencer deciding when the gated group is enabled.
module busclk_gate_fsm
    import busclk_stop_pkg::*;
#(
    parameter int MIN_ON = 10,
    parameter int ON_LAT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_seen,
    input  logic rise_t,
    input  logic fall_t,
    output logic gate_nxt,
    output logic gate_q
);
    localparam int CW = $clog2(MIN_ON + ON_LAT + 1);

    gate_state_e st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          gate_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_RUN_MIN;
            cnt_q  <= '0;
            gate_q <= 1'b1;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            gate_q <= gate_d;
        end
    end

    // Next state and outputs
    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        gate_d = gate_q;
        unique case (st_q)
            ST_RUN_MIN: begin
                if (rise_t) begin
                    if (cnt_q == CW'(MIN_ON - 1)) begin
                        st_d  = ST_RUN;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + CW'(1);
                    end
                end
            end
            ST_RUN: begin
                if (stop_seen) begin
                    st_d  = ST_DRAIN;
                    cnt_d = '0;
                end
            end
            ST_DRAIN: begin
                if (rise_t) begin
                    cnt_d = CW'(1);
                end else if (fall_t && cnt_q == CW'(1)) begin
                    gate_d = 1'b0;
                    st_d   = ST_OFF;
                    cnt_d  = '0;
                end
            end
            ST_OFF: begin
                if (!stop_seen) begin
                    st_d  = ST_WAKE;
                    cnt_d = '0;
                end
            end
            ST_WAKE: begin
                if (rise_t) begin
                    cnt_d = cnt_q + CW'(1);
                end else if (fall_t && cnt_q == CW'(ON_LAT - 1)) begin
                    gate_d = 1'b1;
                    st_d   = ST_RUN_MIN;
                    cnt_d  = '0;
                end
            end
            default: begin
                st_d   = ST_RUN_MIN;
                cnt_d  = '0;
                gate_d = 1'b1;
            end
        endcase
    end

    assign gate_nxt = gate_d;
endmodule

// File: rtl/busclk_stop_ctrl.sv
// Top: free-running and gated bus clocks with synchronized stop control.
module busclk_stop_ctrl #(
    parameter int GCLK_W   = 7,
    parameter int HALF_DIV = 2,
    parameter int MIN_ON   = 10,
    parameter int ON_LAT   = 3,
    parameter int SYNC_N   = 2
) (
    input  logic              clk_ref,
    input  logic              rst_n,
    input  logic              stop_n_async,
    input  logic              stop_qual,
    output logic              free_clk,
    output logic [GCLK_W-1:0] gclk
);
    logic stop_n_s;
    logic stop_seen;
    logic nxt_hi, rise_t, fall_t;
    logic gate_nxt, gate_q;
    logic [GCLK_W-1:0] gclk_q;

    busclk_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) sync_i (
        .clk   (clk_ref),
        .rst_n (rst_n),
        .d     (stop_n_async),
        .q     (stop_n_s)
    );

    busclk_div #(.HALF_DIV(HALF_DIV)) div_i (
        .clk    (clk_ref),
        .rst_n  (rst_n),
        .bus_q  (free_clk),
        .nxt_hi (nxt_hi),
        .rise_t (rise_t),
        .fall_t (fall_t)
    );

    assign stop_seen = ~stop_n_s & stop_qual;

    busclk_gate_fsm #(.MIN_ON(MIN_ON), .ON_LAT(ON_LAT)) fsm_i (
        .clk       (clk_ref),
        .rst_n     (rst_n),
        .stop_seen (stop_seen),
        .rise_t    (rise_t),
        .fall_t    (fall_t),
        .gate_nxt  (gate_nxt),
        .gate_q    (gate_q)
    );

    // Registered outputs: gated copy switches on the same edge as free_clk.
    always_ff @(posedge clk_ref) begin
        if (!rst_n) gclk_q <= '0;
        else        gclk_q <= {GCLK_W{nxt_hi & gate_nxt}};
    end

    assign gclk = gclk_q;
endmodule

// File: rtl/busclk_stop_chk.sv
module busclk_stop_chk #(
    parameter int GCLK_W   = 7,
    parameter int HALF_DIV = 2,
    parameter int MIN_ON   = 10
) (
    input logic              clk_ref,
    input logic              rst_n,
    input logic              free_clk,
    input logic [GCLK_W-1:0] gclk,
    input logic              gate_en
);
    localparam int RW = $clog2(HALF_DIV + 2) + 1;
    localparam int MW = $clog2(MIN_ON + 2) + 1;

    logic [RW-1:0] run_len_q;
    logic          prev_free_q;
    logic [MW-1:0] on_rises_q;
    logic          prev_g_q, prev_en_q;

    always_ff @(posedge clk_ref) begin
        if (!rst_n) begin
            run_len_q   <= '0;
            prev_free_q <= 1'b0;
            on_rises_q  <= '0;
            prev_g_q    <= 1'b0;
            prev_en_q   <= 1'b1;
        end else begin
            prev_free_q <= free_clk;
            run_len_q   <= (free_clk != prev_free_q) ? RW'(1) : run_len_q + RW'(1);
            prev_g_q    <= gclk[0];
            prev_en_q   <= gate_en;
            if (gate_en && !prev_en_q)
                on_rises_q <= '0;
            else if (gclk[0] && !prev_g_q && on_rises_q != {MW{1'b1}})
                on_rises_q <= on_rises_q + MW'(1);
        end
    end

    // R2
    free_period_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        run_len_q <= RW'(HALF_DIV));

    // R9
    gclk_uniform_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (gclk == '0) || (gclk == '1));

    // R6
    gclk_rise_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $rose(gclk[0]) |-> $rose(free_clk));

    // R6
    gclk_fall_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $fell(gclk[0]) |-> $fell(free_clk));

    // R10
    gate_change_low_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        !$stable(gate_en) |-> !free_clk);

    // R7
    min_on_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $fell(gate_en) |-> (on_rises_q >= MW'(MIN_ON)));
endmodule

bind busclk_stop_ctrl busclk_stop_chk #(
    .GCLK_W   (GCLK_W),
    .HALF_DIV (HALF_DIV),
    .MIN_ON   (MIN_ON)
) chk_i (
    .clk_ref  (clk_ref),
    .rst_n    (rst_n),
    .free_clk (free_clk),
    .gclk     (gclk),
    .gate_en  (gate_q)
);

// File: tb/busclk_stop_ctrl_tb_top.sv
`timescale 1ns/1ps
module busclk_stop_ctrl_tb_top;
    localparam int GW   = 7;
    localparam int HALF = 2;
    localparam int MINE = 10;

    logic          clk_ref = 1'b0;
    logic          rst_n   = 1'b0;
    logic          stop_n  = 1'b1;
    logic          qual    = 1'b1;
    logic          free_clk;
    logic [GW-1:0] gclk;

    int checks = 0;
    int errors = 0;

    int free_rises = 0, g_rises = 0;
    int free_err = 0, runt_err = 0, uni_err = 0;
    logic prev_free = 1'b0, prev_g = 1'b0;
    int   free_len = 0, g_len = 0;
    bit   free_valid = 0, g_valid = 0;
    bit   done = 0;

    always #5 clk_ref = ~clk_ref;

    busclk_stop_ctrl dut_i (
        .clk_ref      (clk_ref),
        .rst_n        (rst_n),
        .stop_n_async (stop_n),
        .stop_qual    (qual),
        .free_clk     (free_clk),
        .gclk         (gclk)
    );

    // Output monitors, sampled away from the active edge
    always @(negedge clk_ref) begin
        if (!rst_n) begin
            prev_free = 1'b0; prev_g = 1'b0;
            free_valid = 0; g_valid = 0; free_len = 0; g_len = 0;
        end else begin
            if (gclk != '0 && gclk != '1) uni_err++;
            if (free_clk != prev_free) begin
                if (free_valid && free_len != HALF) free_err++;
                free_valid = 1; free_len = 1;
                if (free_clk) free_rises++;
            end else free_len++;
            if (gclk[0] != prev_g) begin
                if (gclk[0]) begin
                    g_rises++;
                    if (g_valid && g_len < HALF) runt_err++;
                end else if (g_len != HALF) runt_err++;
                g_valid = 1; g_len = 1;
            end else g_len++;
            prev_free = free_clk;
            prev_g    = gclk[0];
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_ref(input int n);
        for (int i = 0; i < n; i++) @(negedge clk_ref);
        #1;
    endtask

    task automatic sync_to_rise();
        @(posedge free_clk);
        @(negedge clk_ref);
        #1;
    endtask

    // R1, R7: request held through reset
    task automatic t_reset_min();
        int base;
        stop_n = 1'b0;
        rst_n  = 1'b0;
        wait_ref(4);
        chk(gclk == '0, "R1 gclk in reset", int'(gclk), 0);
        chk(free_clk == 1'b0, "R1 free_clk in reset", int'(free_clk), 0);
        base = g_rises;
        rst_n = 1'b1;
        wait_ref(160);
        chk(g_rises - base == MINE + 1, "R1 R7 gated rises after reset", g_rises - base, MINE + 1);
    endtask

    // R4, R2: parked low while free clock runs
    task automatic t_parked();
        int gb, fb;
        gb = g_rises; fb = free_rises;
        wait_ref(20);
        chk(g_rises == gb, "R4 no gated rise when stopped", g_rises - gb, 0);
        chk(gclk == '0, "R4 parked low", int'(gclk), 0);
        chk(free_rises - fb == 5, "R2 free clock while stopped", free_rises - fb, 5);
    endtask

    // R5: wake latency
    task automatic t_restart();
        int fb, guard;
        sync_to_rise();
        stop_n = 1'b1;
        fb = free_rises;
        guard = 0;
        while (gclk[0] == 1'b0 && guard < 200) begin
            wait_ref(1);
            guard++;
        end
        chk(free_rises - fb == 3, "R5 free rises until first gated", free_rises - fb, 3);
    endtask

    // R3: off latency from RUN
    task automatic t_stop_latency();
        int gb;
        wait_ref(100);
        sync_to_rise();
        stop_n = 1'b0;
        gb = g_rises;
        wait_ref(40);
        chk(g_rises - gb == 1, "R3 extra gated rises after stop", g_rises - gb, 1);
    endtask

    // R7: minimum-on window after restart
    task automatic t_min_enable();
        int gb, guard;
        gb = g_rises;
        sync_to_rise();
        stop_n = 1'b1;
        guard = 0;
        while (g_rises == gb && guard < 200) begin
            wait_ref(1);
            guard++;
        end
        stop_n = 1'b0;
        wait_ref(120);
        chk(g_rises - gb == MINE + 1, "R7 gated rises with early stop", g_rises - gb, MINE + 1);
        chk(gclk == '0, "R7 parked after window", int'(gclk), 0);
    endtask

    // R8: qualifier
    task automatic t_qualifier();
        int gb, fb;
        stop_n = 1'b1;
        wait_ref(100);
        qual = 1'b0;
        stop_n = 1'b0;
        wait_ref(8);
        gb = g_rises; fb = free_rises;
        wait_ref(60);
        chk(g_rises - gb == free_rises - fb, "R8 request ignored with qualifier low",
            g_rises - gb, free_rises - fb);
        qual = 1'b1;
        wait_ref(40);
        gb = g_rises;
        wait_ref(20);
        chk(g_rises == gb && gclk == '0, "R8 stop once qualifier high", g_rises - gb, 0);
        qual = 1'b0;
        gb = g_rises;
        wait_ref(60);
        chk(g_rises - gb > 0, "R8 restart when qualifier low", g_rises - gb, 1);
        stop_n = 1'b1;
        qual = 1'b1;
        wait_ref(40);
    endtask

    initial begin
        t_reset_min();
        t_parked();
        t_restart();
        t_stop_latency();
        t_parked();
        t_min_enable();
        t_qualifier();
        chk(runt_err == 0, "R6 pulse width violations", runt_err, 0);
        chk(uni_err == 0, "R9 non-uniform gated bits", uni_err, 0);
        chk(free_err == 0, "R2 free clock period violations", free_err, 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule